// File: doc/BRIEF.md
# Parallel Instruction Boundary Marker

The block receives a 16-byte window of fetched code from a small variable-length instruction set and reports which byte offsets begin an instruction. A length-only decoder sits at every offset and works out, in parallel with all the others, how long an instruction would be if one began there. A resolution chain then starts from the window's known entry offset and follows these lengths forward. Each confirmed start validates the offset its length points to, and all speculative results in between are dropped.

The results come out one cycle after a window is accepted. They are a start mask, the lowest few start offsets for the downstream full decoders (each offset with its own valid bit), and a spill count giving the number of bytes of the last instruction that belong to the next window. Boundary state is carried between windows. This includes the case where a window ends inside the prefix run of an instruction, before its opcode byte. A flush input clears that state so that the next window is parsed from offset 0.

Top module: `bnd_marker`

## Requirements
- R1: After reset `out_valid_o`, `start_mask_o`, `slot_vld_o` and `spill_o` are all 0, and the first window accepted is parsed from offset 0.
- R2: Instruction length is P + 1 + T. P is the number of leading prefix bytes (values 0xF0 through 0xF3). T is set by bits [7:6] of the opcode byte: 00 gives 1, 01 gives 2, 10 gives 3, 11 gives 5.
- R3: At most four prefixes belong to one instruction. A byte in the fifth position is taken as the opcode even when its value lies in 0xF0 through 0xF3.
- R4: One cycle after `in_valid_i`, `out_valid_o` is 1. `start_mask_o` bit i (byte i sits in `win_i[8i+7:8i]`) is set exactly when an instruction begins at offset i, reached by chaining lengths from the window's entry offset.
- R5: Slot k of `slot_off_o` (bits [4k+3:4k]) holds the k-th lowest set offset of the mask, in ascending order, with `slot_vld_o[k]` set. Slots beyond the number of starts have valid 0 and offset 0.
- R6: `spill_o` is the number of bytes of the window's last instruction that lie beyond offset 15, or 0 when that instruction ends exactly at the window edge. The next window's first start is at offset `spill_o`.
- R7: When a window ends before the opcode of its last instruction, `spill_o` is 0. The next window then continues that instruction from offset 0 without marking a start there. Its prefix count goes on from where it stopped, so the four-prefix limit of R3 applies to the instruction as a whole.
- R8: A flush clears the carried state. If `in_valid_i` is high in the same cycle, that window is parsed from offset 0. A flush alone makes the next window start at offset 0.
- R9: A cycle without `in_valid_i` or `flush_i` leaves the carried state and the result outputs unchanged and drives `out_valid_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Window on `win_i` is accepted this cycle |
| flush_i | input | 1 | Clear the carried boundary state |
| win_i | input | 128 | Window bytes, byte i in bits [8i+7:8i] |
| out_valid_o | output | 1 | Results below belong to the window accepted last cycle |
| start_mask_o | output | 16 | One bit per offset, set where an instruction begins |
| slot_off_o | output | 16 | Four 4-bit start offsets, lowest first |
| slot_vld_o | output | 4 | Valid bit per slot |
| spill_o | output | 4 | Bytes of the last instruction falling into the next window |

## Verification
The assertions assume that `win_i` holds known values whenever the length decoders are read, and that a flush may coincide with a window. The bench drives a defined window at all times and mixes flush with and without `in_valid_i`. They also assume that carried state only ever comes from the block itself: at most nine bytes of skip, and a pending prefix run only with a zero skip. The stimulus never forces the carry. It only reaches edge cases through real windows, such as prefix runs cut at the window end, five-prefix sequences and ten-byte instructions that cross the edge, and random byte streams.

// File: rtl/bnd_pkg.sv
package bnd_pkg;

    localparam int WIN_BYTES = 16;
    localparam int MAX_PFX   = 4;
    localparam int MAX_TAIL  = 5;
    localparam int MAX_LEN   = MAX_PFX + 1 + MAX_TAIL;
    localparam int LOOK      = MAX_PFX + 1;
    localparam int OFF_W     = $clog2(WIN_BYTES);
    localparam int LEN_W     = $clog2(MAX_LEN + 1);
    localparam int PFX_W     = $clog2(MAX_PFX + 1);
    localparam int AV_W      = $clog2(LOOK + 1);

    // speculative length result for one offset
    typedef struct packed {
        logic             inc;   // window ended before the opcode
        logic [PFX_W-1:0] pfx;   // prefixes seen when inc is set
        logic [LEN_W-1:0] len;   // full length when inc is clear
    } len_res_t;

    // state handed from one window to the next
    typedef struct packed {
        logic             pend;  // prefix run still open at offset 0
        logic [PFX_W-1:0] pfx;   // prefixes already consumed
        logic [OFF_W-1:0] skip;  // entry offset of the next window
    } carry_t;

    function automatic logic is_prefix(input logic [7:0] b);
        return b[7:2] == 6'b111100;
    endfunction

    function automatic int tail_len(input logic [7:0] b);
        case (b[7:6])
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 3;
            default: return MAX_TAIL;
        endcase
    endfunction

endpackage

// File: rtl/bnd_len_dec.sv
module bnd_len_dec
    import bnd_pkg::*;
(
    input  logic [8*LOOK-1:0] look_i,   // bytes from this offset onward
    input  logic [AV_W-1:0]   avail_i,  // how many of them are inside the window
    input  logic [PFX_W-1:0]  cap_i,    // prefixes still allowed
    output len_res_t          res_o
);
    logic [7:0] byte_v;
    logic       done;

    always_comb begin
        res_o  = '0;
        done   = 1'b0;
        byte_v = '0;
        for (int k = 0; k < LOOK; k++) begin
            byte_v = look_i[k*8 +: 8];
            if (!done) begin
                if (k >= int'(avail_i)) begin
                    res_o.inc = 1'b1;
                    res_o.pfx = PFX_W'(k);
                    done      = 1'b1;
                end else if (k == int'(cap_i) || !is_prefix(byte_v)) begin
                    res_o.len = LEN_W'(k + 1 + tail_len(byte_v));
                    done      = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bnd_chain.sv
module bnd_chain
    import bnd_pkg::*;
(
    input  len_res_t             res_i [WIN_BYTES],
    input  carry_t               cin_i,
    output logic [WIN_BYTES-1:0] mask_o,
    output carry_t               cout_o
);
    logic [WIN_BYTES-1:0] reach;
    int                   e;

    // ascending walk: every hop moves forward, so one pass resolves the cascade
    always_comb begin
        reach  = '0;
        cout_o = '0;
        e      = 0;
        if (cin_i.pend) reach[0] = 1'b1;
        else            reach[cin_i.skip] = 1'b1;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (reach[i]) begin
                if (res_i[i].inc) begin
                    cout_o.pend = 1'b1;
                    cout_o.pfx  = res_i[i].pfx;
                end else begin
                    e = i + int'(res_i[i].len);
                    if (e < WIN_BYTES) reach[e] = 1'b1;
                    else               cout_o.skip = OFF_W'(e - WIN_BYTES);
                end
            end
        end
        mask_o = reach;
        if (cin_i.pend) mask_o[0] = 1'b0;   // continuation, not a new start
    end

endmodule

// File: rtl/bnd_slot_pick.sv
module bnd_slot_pick
    import bnd_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic [WIN_BYTES-1:0]   mask_i,
    output logic [NSLOT*OFF_W-1:0] off_o,
    output logic [NSLOT-1:0]       vld_o
);
    int n;

    always_comb begin
        off_o = '0;
        vld_o = '0;
        n     = 0;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (mask_i[i] && n < NSLOT) begin
                off_o[n*OFF_W +: OFF_W] = OFF_W'(i);
                vld_o[n]                = 1'b1;
                n                       = n + 1;
            end
        end
    end

endmodule

// File: rtl/bnd_marker.sv
module bnd_marker
    import bnd_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid_i,
    input  logic                   flush_i,
    input  logic [8*WIN_BYTES-1:0] win_i,
    output logic                   out_valid_o,
    output logic [WIN_BYTES-1:0]   start_mask_o,
    output logic [NSLOT*OFF_W-1:0] slot_off_o,
    output logic [NSLOT-1:0]       slot_vld_o,
    output logic [OFF_W-1:0]       spill_o
);
    carry_t               carry_q, cin, cout;
    logic [PFX_W-1:0]     cap0;
    len_res_t             res [WIN_BYTES];
    logic [WIN_BYTES-1:0] mask;
    logic [NSLOT*OFF_W-1:0] off;
    logic [NSLOT-1:0]     vld;

    assign cin  = flush_i ? carry_t'('0) : carry_q;
    assign cap0 = cin.pend ? PFX_W'(MAX_PFX) - cin.pfx : PFX_W'(MAX_PFX);

    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_off
        localparam int AV = (WIN_BYTES - g < LOOK) ? WIN_BYTES - g : LOOK;
        logic [8*LOOK-1:0] look;
        for (genvar b = 0; b < LOOK; b++) begin : g_byte
            if (g + b < WIN_BYTES) begin : g_in
                assign look[b*8 +: 8] = win_i[(g+b)*8 +: 8];
            end else begin : g_out
                assign look[b*8 +: 8] = 8'h00;
            end
        end
        bnd_len_dec u_dec (
            .look_i  (look),
            .avail_i (AV_W'(AV)),
            .cap_i   (g == 0 ? cap0 : PFX_W'(MAX_PFX)),
            .res_o   (res[g])
        );
        AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
            !res[g].inc |-> (res[g].len >= LEN_W'(2) && res[g].len <= LEN_W'(MAX_LEN))); // R2
    end

    bnd_chain u_chain (
        .res_i  (res),
        .cin_i  (cin),
        .mask_o (mask),
        .cout_o (cout)
    );

    bnd_slot_pick #(.NSLOT(NSLOT)) u_pick (
        .mask_i (mask),
        .off_o  (off),
        .vld_o  (vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q      <= '0;
            out_valid_o  <= 1'b0;
            start_mask_o <= '0;
            slot_off_o   <= '0;
            slot_vld_o   <= '0;
            spill_o      <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                carry_q      <= cout;
                start_mask_o <= mask;
                slot_off_o   <= off;
                slot_vld_o   <= vld;
                spill_o      <= cout.skip;
            end else if (flush_i) begin
                carry_q <= '0;
            end
        end
    end

    AST_SKIP_BOUND: assert property (@(posedge clk) disable iff (rst)
        carry_q.skip <= OFF_W'(MAX_LEN - 1)); // R6
    AST_FIRST_START: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && !flush_i && !carry_q.pend |=> start_mask_o[$past(carry_q.skip)]); // R6
    AST_PEND_EXCL: assert property (@(posedge clk) disable iff (rst)
        carry_q.pend |-> carry_q.skip == '0); // R7
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flush_i && !in_valid_i |=> carry_q == '0); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i && !flush_i |=> $stable(carry_q) && $stable(start_mask_o) && !out_valid_o); // R9
    AST_SLOT_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        slot_vld_o[0] |-> start_mask_o[slot_off_o[OFF_W-1:0]]); // R5
    AST_SLOT_ASCEND: assert property (@(posedge clk) disable iff (rst)
        slot_vld_o[1] |-> slot_off_o[2*OFF_W-1:OFF_W] > slot_off_o[OFF_W-1:0]); // R5
    AST_SLOT_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(start_mask_o) <= NSLOT |-> $countones(slot_vld_o) == $countones(start_mask_o)); // R5

endmodule

// File: tb/bnd_marker_tb_top.sv
module bnd_marker_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid_i = 1'b0;
    logic         flush_i = 1'b0;
    logic [127:0] win_i = '0;
    logic         out_valid_o;
    logic [15:0]  start_mask_o;
    logic [15:0]  slot_off_o;
    logic [3:0]   slot_vld_o;
    logic [3:0]   spill_o;

    always #5 clk = ~clk;

    bnd_marker dut_i (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .flush_i(flush_i),
        .win_i(win_i), .out_valid_o(out_valid_o), .start_mask_o(start_mask_o),
        .slot_off_o(slot_off_o), .slot_vld_o(slot_vld_o), .spill_o(spill_o)
    );

    typedef struct packed {
        logic [15:0] mask;
        logic [15:0] off;
        logic [3:0]  vld;
        logic [3:0]  spill;
    } exp_t;

    exp_t   exp_q[$];
    string  tag_q[$];
    int     n_chk = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    logic [127:0] w;
    logic [15:0]  last_mask;

    // serial reference walk with its own carry
    bit m_pend = 0;
    int m_pfx  = 0;
    int m_skip = 0;

    function automatic logic [7:0] bt(input logic [127:0] x, input int i);
        return x[i*8 +: 8];
    endfunction
    function automatic bit isp(input logic [7:0] b);
        return (b >= 8'hF0 && b <= 8'hF3);
    endfunction
    function automatic int tl(input logic [7:0] b);
        int t[4] = '{1, 2, 3, 5};
        return t[b[7:6]];
    endfunction

    task automatic model(input logic [127:0] x, output exp_t e);
        int i, k, p, en, n;
        bit np; int npfx, nskip;
        np = 0; npfx = 0; nskip = 0; e = '0;
        if (m_pend) begin
            k = m_pfx; p = 0;
            while (k < 4 && isp(bt(x, p))) begin k++; p++; end
            i = p + 1 + tl(bt(x, p));
        end else i = m_skip;
        while (i < 16) begin
            e.mask[i] = 1'b1;
            k = 0; p = i;
            while (p < 16 && k < 4 && isp(bt(x, p))) begin k++; p++; end
            if (p >= 16) begin np = 1; npfx = k; i = 16; end
            else begin
                en = p + 1 + tl(bt(x, p));
                if (en >= 16) nskip = en - 16;
                i = en;
            end
        end
        n = 0;
        for (int j = 0; j < 16; j++)
            if (e.mask[j] && n < 4) begin e.off[n*4 +: 4] = 4'(j); e.vld[n] = 1'b1; n++; end
        e.spill = 4'(nskip);
        m_pend = np; m_pfx = npfx; m_skip = nskip;
    endtask

    task automatic send(input logic [127:0] x, input bit fl, input string tag);
        exp_t e;
        if (fl) begin m_pend = 0; m_pfx = 0; m_skip = 0; end
        model(x, e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_mask  = e.mask;
        in_valid_i = 1'b1; flush_i = fl; win_i = x;
        @(negedge clk);
    endtask

    task automatic idle(input bit fl);
        if (fl) begin m_pend = 0; m_pfx = 0; m_skip = 0; end
        in_valid_i = 1'b0; flush_i = fl;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 16; i++) w[i*8 +: 8] = v;
    endtask
    task automatic pb(input int i, input logic [7:0] v);
        w[i*8 +: 8] = v;
    endtask

    // monitor: compare every result against the oldest expected item
    always @(negedge clk) begin
        if (!rst && out_valid_o) begin
            if (exp_q.size() == 0) chk("R4", "unexpected result", 32'(start_mask_o), 32'hFFFF_FFFF);
            else begin
                exp_t e; string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                chk(t, "mask R4", 32'(start_mask_o), 32'(e.mask));
                chk(t, "slot offsets R5", 32'(slot_off_o), 32'(e.off));
                chk(t, "slot valids R5", 32'(slot_vld_o), 32'(e.vld));
                chk(t, "spill R6", 32'(spill_o), 32'(e.spill));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset out_valid", 32'(out_valid_o), 0);
        chk("R1", "reset mask", 32'(start_mask_o), 0);
        chk("R1", "reset slot valids", 32'(slot_vld_o), 0);
        chk("R1", "reset spill", 32'(spill_o), 0);

        fill(8'h00); send(w, 0, "R1");                        // even starts from offset 0
        fill(8'h11); pb(0, 8'h00); pb(2, 8'h40); pb(5, 8'h80);
        pb(9, 8'hC0); pb(15, 8'h00); send(w, 0, "R2");        // lengths 2,3,4,6 then spill 1
        fill(8'h00); send(w, 0, "R6");                        // entry at offset 1
        fill(8'h40); send(w, 1, "R8");                        // flush with window, length 3
        fill(8'h00); pb(2, 8'hF0); pb(3, 8'hF1); pb(4, 8'hF2); pb(5, 8'hF3);
        pb(6, 8'hF0); send(w, 0, "R3");                       // fifth prefix acts as opcode
        fill(8'h11); pb(0, 8'hC0); pb(6, 8'hC0); pb(12, 8'h00);
        pb(14, 8'hF0); pb(15, 8'hF2); send(w, 0, "R7");       // prefix run cut at edge
        fill(8'h00); pb(0, 8'hF3); pb(1, 8'hF1); pb(2, 8'hF0);
        for (int i = 3; i < 8; i++) pb(i, 8'h11);
        send(w, 0, "R7");                                     // continuation, cap reached at byte 2
        idle(0);
        @(negedge clk);
        chk("R9", "idle out_valid", 32'(out_valid_o), 0);
        chk("R9", "idle mask held", 32'(start_mask_o), 32'(last_mask));
        fill(8'h80); send(w, 0, "R9");                        // carry survived idle cycles
        fill(8'h11); for (int i = 0; i < 4; i++) begin pb(i, 8'hF0); pb(10 + i, 8'hF0); end
        pb(4, 8'hC0); pb(14, 8'hC0); send(w, 0, "R5");        // only two starts
        fill(8'h00); send(w, 0, "R6");                        // entry at offset 4
        fill(8'hF0); pb(13, 8'h00); send(w, 0, "R7");
        idle(1);                                              // flush alone
        fill(8'h40); send(w, 0, "R8");

        lf = 32'hACE1_2345;
        for (int n = 0; n < 80; n++) begin
            for (int i = 0; i < 16; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                pb(i, (lf[3:0] < 4'd5) ? {6'b111100, lf[5:4]} : lf[11:4]);
            end
            send(w, (n % 17) == 16, "R4");
            if ((n % 9) == 8) idle(0);
        end
        idle(0);
        repeat (3) @(negedge clk);
        chk("R4", "results outstanding", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule